// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the 32-bit program counter of a small single-cycle processor and produces the fetched instruction word for the current PC. The PC advances on every rising clock edge. It has no write enable. The next value is one of three addresses:

- the sequential address, PC + 4;
- a PC-relative branch target, built from the low 16 bits of the current instruction;
- a pseudo-absolute jump target. This keeps the top four PC bits and takes the rest from the low 26 bits of the current instruction.

Instruction storage is a small word array inside the block. It is read combinationally at the current PC and is filled through a write port. A testbench or a loader uses this port before the program runs. The branch control input means "the current instruction is a branch". A branch is taken only when the datapath's equality flag is also high.

Top module: `pc_fetch_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0 at the rising edge where reset is high; reset takes precedence over every other control.
- R2: When jump is low and the branch is not taken, the PC becomes PC + 4 at each rising edge, modulo 2^32.
- R3: When branch select and the equality flag are both 1 and jump is 0, the next PC is PC + 4 + (sign-extended instr[15:0] shifted left by 2). The addition wraps modulo 2^32.
- R4: Branch select alone, or the equality flag alone, does not redirect the PC; the next PC is PC + 4.
- R5: When jump is 1, the next PC is {PC[31:28], instr[25:0], 2'b00}.
- R6: Jump takes priority over a taken branch when both are requested in the same cycle.
- R7: The instruction output equals the stored word at index PC[9:2] in the same cycle. PC[1:0] and PC[31:10] do not select the word.
- R8: When the load enable is 1 at a rising edge, the load data is stored at the load index. From that edge on, the instruction output shows the new word whenever the PC selects that index.
- R9: The PC is always a multiple of 4 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | Current instruction is a branch |
| eq_flag | input | 1 | Equality result of the two source operands |
| jmp | input | 1 | Current instruction is a jump |
| ld_en | input | 1 | Instruction store write enable |
| ld_addr | input | 8 | Word index written by the load port |
| ld_data | input | 32 | Word written by the load port |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word at the current PC |

## Verification
The checker assumes that reset is asserted for at least one edge before anything else is observed. It also assumes that the control inputs are stable around the rising edge, so that `$past` of the PC and the instruction gives the operands the next-address logic used. The stimulus drives every input one time unit after a rising edge and holds it for the whole cycle. It starts with a reset that covers the whole preload of the instruction store. Random cycles then mix all eight combinations of branch, equality and jump with random instruction words, and the branch targets reach negative offsets and wrap below zero.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int PC_W  = 32;
  localparam int IMM_W = 16;
  localparam int TGT_W = 26;
  localparam int HI_W  = PC_W - TGT_W - 2;

  typedef logic [PC_W-1:0] addr_t;

  // Sequential successor of a fetch address.
  function automatic addr_t seq_addr(input addr_t cur);
    return cur + addr_t'(4);
  endfunction

  // PC-relative target: word offset sign-extended, scaled to bytes.
  function automatic addr_t branch_addr(input addr_t seq, input logic [IMM_W-1:0] off);
    return seq + {{(PC_W-IMM_W-2){off[IMM_W-1]}}, off, 2'b00};
  endfunction

  // Region-relative target: upper bits kept, word index replaced.
  function automatic addr_t jump_addr(input logic [HI_W-1:0] hi, input logic [TGT_W-1:0] tgt);
    return {hi, tgt, 2'b00};
  endfunction
endpackage

// File: rtl/ifu_imem.sv
module ifu_imem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
  import ifu_pkg::*;
(
  input  addr_t             cur_pc,
  input  logic [IMM_W-1:0]  off16,
  input  logic [TGT_W-1:0]  tgt26,
  input  logic              br_sel,
  input  logic              eq_flag,
  input  logic              jmp,
  output logic              br_taken,
  output addr_t             seq_pc,
  output addr_t             br_pc,
  output addr_t             jmp_pc,
  output addr_t             nxt_pc
);
  assign br_taken = br_sel & eq_flag;
  assign seq_pc   = seq_addr(cur_pc);
  assign br_pc    = branch_addr(seq_pc, off16);
  assign jmp_pc   = jump_addr(cur_pc[PC_W-1 -: HI_W], tgt26);

  always_comb begin
    if (jmp)           nxt_pc = jmp_pc;
    else if (br_taken) nxt_pc = br_pc;
    else               nxt_pc = seq_pc;
  end
endmodule

// File: rtl/pc_fetch_unit.sv
module pc_fetch_unit
  import ifu_pkg::*;
#(
  parameter int          IMEM_AW  = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               br_sel,
  input  logic               eq_flag,
  input  logic               jmp,
  input  logic               ld_en,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [31:0]        ld_data,
  output logic [31:0]        pc,
  output logic [31:0]        instr
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IMEM_AW - 1;

  addr_t pc_q;
  addr_t nxt_pc;
  addr_t seq_pc;
  addr_t br_pc;
  addr_t jmp_pc;
  logic  br_taken;

  ifu_imem #(.AW(IMEM_AW), .DW(PC_W)) u_imem (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[IDX_HI:IDX_LO]),
    .rdata (instr)
  );

  ifu_next_pc u_npc (
    .cur_pc   (pc_q),
    .off16    (instr[IMM_W-1:0]),
    .tgt26    (instr[TGT_W-1:0]),
    .br_sel   (br_sel),
    .eq_flag  (eq_flag),
    .jmp      (jmp),
    .br_taken (br_taken),
    .seq_pc   (seq_pc),
    .br_pc    (br_pc),
    .jmp_pc   (jmp_pc),
    .nxt_pc   (nxt_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= nxt_pc;
  end

  assign pc = pc_q;
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk (
  input logic        clk,
  input logic        rst,
  input logic        br_sel,
  input logic        eq_flag,
  input logic        jmp,
  input logic [31:0] pc,
  input logic [31:0] instr
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'h0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !(br_sel && eq_flag)) |=> pc == $past(pc) + 32'd4);

  // R3
  branch_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (!jmp && br_sel && eq_flag) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    jmp |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});

  // R9
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
endmodule

bind pc_fetch_unit ifu_fetch_chk u_chk (.*);

// File: tb/pc_fetch_unit_tb.sv
module pc_fetch_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, br_sel, eq_flag, jmp, ld_en;
  logic [7:0]  ld_addr;
  logic [31:0] ld_data, pc, instr;

  logic [31:0] mdl_mem [256];
  logic [31:0] mdl_pc;
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_fetch_unit u_dut (.*);

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic [31:0] w,
                                           input bit b, input bit e, input bit j);
    int signed off;
    if (j) return (p & 32'hF000_0000) | ({6'd0, w[25:0]} << 2);
    if (b && e) begin
      off = int'($signed(w[15:0])) * 4;
      return p + 32'd4 + 32'(off);
    end
    return p + 32'd4;
  endfunction

  function automatic string tag_of(input bit b, input bit e, input bit j);
    if (j && b && e) return "R6";
    if (j)           return "R5";
    if (b && e)      return "R3";
    if (b || e)      return "R4";
    return "R2";
  endfunction

  task automatic check_pc(input string tag, input logic [31:0] exp);
    vectors++;
    if (pc !== exp) begin
      errors++;
      $display("FAIL %s pc got %h expected %h", tag, pc, exp);
    end
  endtask

  task automatic check_instr(input string tag);
    logic [31:0] exp = mdl_mem[mdl_pc[9:2]];
    vectors++;
    if (instr !== exp) begin
      errors++;
      $display("FAIL %s instr got %h expected %h (pc %h)", tag, instr, exp, pc);
    end
  endtask

  // One cycle of execution with optional mid-run store write (R8).
  task automatic step(input bit b, input bit e, input bit j,
                      input bit wr, input logic [7:0] wa, input logic [31:0] wd);
    logic [31:0] exp;
    br_sel = b; eq_flag = e; jmp = j;
    ld_en = wr; ld_addr = wa; ld_data = wd;
    exp = exp_next(mdl_pc, mdl_mem[mdl_pc[9:2]], b, e, j);
    @(posedge clk); #1;
    ld_en = 1'b0;
    if (wr) mdl_mem[wa] = wd;
    mdl_pc = exp;
    check_pc(tag_of(b, e, j), exp);
    check_instr(wr ? "R8" : "R7");
    // R9: alignment of every PC
    vectors++;
    if (pc[1:0] !== 2'b00) begin
      errors++;
      $display("FAIL R9 pc low bits got %b expected 00", pc[1:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; br_sel = 0; eq_flag = 0; jmp = 0;
    ld_en = 0; ld_addr = '0; ld_data = '0;
    @(posedge clk); #1;
    // R1: reset state
    check_pc("R1", 32'h0);

    // Preload the whole store while held in reset (R8)
    for (int i = 0; i < 256; i++) begin
      logic [31:0] w = $urandom;
      if (i == 0) w = 32'h1000_FFFE;      // branch offset -2 words
      if (i == 2) w = 32'h0800_0040;      // jump index 0x40
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = w; mdl_mem[i] = w;
      @(posedge clk); #1;
    end
    ld_en = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    mdl_pc = 32'h0;
    check_pc("R1", 32'h0);
    check_instr("R8");

    // Directed corners
    step(1, 1, 0, 0, 8'd0, 32'd0);   // R3 negative offset wraps to 0xFFFFFFFC
    step(0, 0, 0, 0, 8'd0, 32'd0);   // R2 wrap 0xFFFFFFFC -> 0
    step(1, 0, 0, 0, 8'd0, 32'd0);   // R4 select without equality
    step(0, 1, 0, 0, 8'd0, 32'd0);   // R4 equality without select
    step(1, 1, 1, 0, 8'd0, 32'd0);   // R6 jump beats branch
    // R8: overwrite the word the next PC will select
    step(0, 0, 0, 1, mdl_pc[9:2] + 8'd1, 32'hDEAD_BEEF);

    // Random program walk
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] c = 3'($urandom);
      bit wr = ($urandom % 8) == 0;
      logic [7:0] wa = 8'($urandom);
      logic [31:0] wd = $urandom;
      step(c[0], c[1], c[2], wr, wa, wd);
      if ((n % 500) == 499) begin
        rst = 1'b1; br_sel = 1; eq_flag = 1; jmp = 1;
        @(posedge clk); #1;
        rst = 1'b0;
        mdl_pc = 32'h0;
        check_pc("R1", 32'h0);   // reset wins over jump and branch
        check_instr("R7");
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule